// File: doc/BRIEF.md
# DVFS and Clock-Gating Power Controller

This controller sets the operating point of a soft processor and decides which clocks run. A cooperating control unit sends a command made of a cycle count, a deadline, and a mask of the peripherals the next task needs. The controller picks the lowest discrete level whose frequency finishes that work in time. It then moves the external voltage regulator and the clock generator to that level in a safe order. Level k runs at frequency FMIN + k*ALPHA_STEP*DELTA_F. With the default parameters these are 4, 8, 12 and 16 cycles per deadline tick for levels 0 to 3.

To raise the level, the voltage code goes up first. The frequency code follows only once the regulator reports a good supply. To lower the level, the frequency drops first, the voltage drops on the next edge, and the controller then waits for the supply to settle. Each wait has a timeout. If it expires, the controller raises a sticky error flag and parks at the safe, higher supply. The processor clock enable follows the idle and wake inputs with one register of latency. The peripheral clock enables follow the mask of the last accepted command.

The state machine has five states:
- ST_STEADY: no transition in progress.
- ST_SETTLE_UP: the voltage has been raised and the controller waits for the supply to settle.
- ST_STEP_V_DN: the frequency has been lowered and the voltage is lowered on the next edge.
- ST_SETTLE_DN: the controller waits for the lowered supply to settle.
- ST_FAULT: absorbing until reset.

The transitions are:
- STEADY->SETTLE_UP on an accepted request with a higher target.
- STEADY->STEP_V_DN on an accepted request with a lower target.
- STEP_V_DN->SETTLE_DN always, after one cycle.
- SETTLE_UP->STEADY and SETTLE_DN->STEADY when vgood is high.
- SETTLE_UP->FAULT and SETTLE_DN->FAULT on timeout.

Top module: `pwr_dvfs_ctrl`

## Requirements
- R1: After reset, freq_lvl and volt_lvl are both the top level (3), cpu_clk_en is 1, periph_clk_en is all zero, and busy and settle_err are 0.
- R2: An accepted request targets the lowest level k with req_cycles <= req_deadline*(FMIN+k*ALPHA_STEP*DELTA_F). If no level qualifies, the target is the top level. After the transition, freq_lvl and volt_lvl both equal the target.
- R3: On a raise, volt_lvl takes the target at the accept edge while freq_lvl keeps its old value. freq_lvl takes the target on the first edge in ST_SETTLE_UP at which vgood is sampled high.
- R4: On a lower, freq_lvl takes the target at the accept edge, and volt_lvl takes it one edge later. The controller then waits for vgood before returning to ST_STEADY.
- R5: freq_lvl and volt_lvl never change on the same edge, and volt_lvl is never below freq_lvl.
- R6: A request whose target equals the current level changes no level and causes no transition: busy stays 0. The peripheral mask is still loaded.
- R7: A request is accepted only in ST_STEADY. A request while busy is 1 changes neither the levels nor periph_clk_en.
- R8: If vgood is not sampled high within SETTLE_TMO cycles in a settle state, settle_err becomes 1 and the controller enters ST_FAULT.
  - On a raise timeout, freq_lvl keeps the old level and volt_lvl keeps the target.
  - On a lower timeout, volt_lvl returns to the level held before the request.
  - ST_FAULT holds the levels, keeps settle_err high and ignores requests until reset.
- R9: cpu_clk_en is registered. At each edge it takes (not cpu_idle) or wake_req, so a wake restores the processor clock one edge after it is applied.
- R10: periph_clk_en bit i is 1 exactly when bit i of the mask of the last accepted request was 1. It changes only at an accept edge.
- R11: busy is 1 from the accept edge of a level-changing request until the edge that returns the controller to ST_STEADY, and it stays 1 in ST_FAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command strobe from the control unit |
| req_cycles | input | CYC_W | Work of the next task, in cycles |
| req_deadline | input | DL_W | Deadline of the next task, in ticks |
| req_periph | input | NUM_PERIPH | Peripherals the next task needs |
| cpu_idle | input | 1 | Processor has no work |
| wake_req | input | 1 | Wake event for the processor |
| vgood | input | 1 | Regulator reports the supply settled |
| freq_lvl | output | LW | Level code to the clock generator |
| volt_lvl | output | LW | Voltage code to the regulator |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| busy | output | 1 | Transition in progress or fault |
| settle_err | output | 1 | Sticky settle-timeout flag |

## Verification
Some rules hold on every cycle, and the checker watches these continuously:
- the voltage code never falls below the frequency code;
- the two codes never move on the same edge;
- the frequency rises only after vgood;
- the processor clock enable tracks idle and wake with one cycle of latency;
- the peripheral enables move only on accepted requests;
- the fault flag and the fault levels are held.

Other behaviour only the bench scenarios can show: the choice of the lowest level that meets the deadline (including exact-boundary and unreachable deadlines), the full order of raise and lower sequences, requests ignored while busy, and the levels left behind after each kind of timeout.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

    typedef enum logic [2:0] {
        ST_STEADY    = 3'd0,
        ST_SETTLE_UP = 3'd1,
        ST_STEP_V_DN = 3'd2,
        ST_SETTLE_DN = 3'd3,
        ST_FAULT     = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/pwr_level_sel.sv
module pwr_level_sel #(
    parameter int NUM_LVL    = 4,
    parameter int CYC_W      = 16,
    parameter int DL_W       = 8,
    parameter int FMIN       = 4,
    parameter int DELTA_F    = 4,
    parameter int ALPHA_STEP = 1,
    parameter int LW         = $clog2(NUM_LVL)
) (
    input  logic [CYC_W-1:0] cycles,
    input  logic [DL_W-1:0]  deadline,
    output logic [LW-1:0]    level
);
    localparam int FMAX  = FMIN + (NUM_LVL - 1) * ALPHA_STEP * DELTA_F;
    localparam int CAP_W = DL_W + $clog2(FMAX + 1);
    localparam int CMP_W = (CYC_W > CAP_W) ? CYC_W : CAP_W;

    logic [NUM_LVL-1:0] meets;

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        localparam int FREQ_K = FMIN + k * ALPHA_STEP * DELTA_F;
        logic [CMP_W-1:0] capacity;
        assign capacity = CMP_W'(deadline) * CMP_W'(FREQ_K);
        assign meets[k] = (CMP_W'(cycles) <= capacity);
    end

    always_comb begin
        level = LW'(NUM_LVL - 1);
        for (int k = NUM_LVL - 1; k >= 0; k--) begin
            if (meets[k]) begin
                level = LW'(k);
            end
        end
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int SETTLE_TMO = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(SETTLE_TMO + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != TW'(SETTLE_TMO - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == TW'(SETTLE_TMO - 1));
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
    parameter int NUM_PERIPH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_idle,
    input  logic                  wake_req,
    input  logic                  mask_load,
    input  logic [NUM_PERIPH-1:0] mask_in,
    output logic                  cpu_en,
    output logic [NUM_PERIPH-1:0] periph_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en <= 1'b1;
        end else begin
            cpu_en <= !cpu_idle || wake_req;
        end
    end

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                periph_en[i] <= 1'b0;
            end else if (mask_load) begin
                periph_en[i] <= mask_in[i];
            end
        end
    end
endmodule

// File: rtl/pwr_dvfs_ctrl.sv
module pwr_dvfs_ctrl
    import pwr_ctl_pkg::*;
#(
    parameter int NUM_LVL    = 4,
    parameter int CYC_W      = 16,
    parameter int DL_W       = 8,
    parameter int NUM_PERIPH = 4,
    parameter int FMIN       = 4,
    parameter int DELTA_F    = 4,
    parameter int ALPHA_STEP = 1,
    parameter int SETTLE_TMO = 8,
    parameter int LW         = $clog2(NUM_LVL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [CYC_W-1:0]      req_cycles,
    input  logic [DL_W-1:0]       req_deadline,
    input  logic [NUM_PERIPH-1:0] req_periph,
    input  logic                  cpu_idle,
    input  logic                  wake_req,
    input  logic                  vgood,
    output logic [LW-1:0]         freq_lvl,
    output logic [LW-1:0]         volt_lvl,
    output logic                  cpu_clk_en,
    output logic [NUM_PERIPH-1:0] periph_clk_en,
    output logic                  busy,
    output logic                  settle_err
);
    localparam logic [LW-1:0] TOP_LVL = LW'(NUM_LVL - 1);

    pwr_state_e    state_q, state_nx;
    logic [LW-1:0] tgt_lvl, tgt_q, src_q;
    logic          req_acc, go_up, go_dn, settling, tmo;

    pwr_level_sel #(
        .NUM_LVL(NUM_LVL), .CYC_W(CYC_W), .DL_W(DL_W), .FMIN(FMIN),
        .DELTA_F(DELTA_F), .ALPHA_STEP(ALPHA_STEP), .LW(LW)
    ) u_sel (
        .cycles(req_cycles),
        .deadline(req_deadline),
        .level(tgt_lvl)
    );

    assign settling = (state_q == ST_SETTLE_UP) || (state_q == ST_SETTLE_DN);

    pwr_settle_timer #(.SETTLE_TMO(SETTLE_TMO)) u_tmr (
        .clk(clk),
        .rst_n(rst_n),
        .run(settling),
        .expired(tmo)
    );

    assign req_acc = req_valid && (state_q == ST_STEADY);
    assign go_up   = tgt_lvl > freq_lvl;
    assign go_dn   = tgt_lvl < freq_lvl;

    pwr_gate_ctrl #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
        .clk(clk),
        .rst_n(rst_n),
        .cpu_idle(cpu_idle),
        .wake_req(wake_req),
        .mask_load(req_acc),
        .mask_in(req_periph),
        .cpu_en(cpu_clk_en),
        .periph_en(periph_clk_en)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_STEADY: begin
                if (req_acc && go_up)      state_nx = ST_SETTLE_UP;
                else if (req_acc && go_dn) state_nx = ST_STEP_V_DN;
            end
            ST_SETTLE_UP: begin
                if (vgood)    state_nx = ST_STEADY;
                else if (tmo) state_nx = ST_FAULT;
            end
            ST_STEP_V_DN: state_nx = ST_SETTLE_DN;
            ST_SETTLE_DN: begin
                if (vgood)    state_nx = ST_STEADY;
                else if (tmo) state_nx = ST_FAULT;
            end
            ST_FAULT: state_nx = ST_FAULT;
            default:  state_nx = ST_FAULT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STEADY;
        else        state_q <= state_nx;
    end

    // Output and level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_lvl   <= TOP_LVL;
            volt_lvl   <= TOP_LVL;
            tgt_q      <= TOP_LVL;
            src_q      <= TOP_LVL;
            settle_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STEADY: begin
                    if (req_acc) begin
                        tgt_q <= tgt_lvl;
                        src_q <= freq_lvl;
                        if (go_up)      volt_lvl <= tgt_lvl;
                        else if (go_dn) freq_lvl <= tgt_lvl;
                    end
                end
                ST_SETTLE_UP: begin
                    if (vgood) freq_lvl <= tgt_q;
                end
                ST_STEP_V_DN: volt_lvl <= tgt_q;
                ST_SETTLE_DN: begin
                    if (!vgood && tmo) volt_lvl <= src_q;
                end
                ST_FAULT: ;
                default: ;
            endcase
            if (state_nx == ST_FAULT) settle_err <= 1'b1;
        end
    end

    assign busy = (state_q != ST_STEADY);
endmodule

// File: rtl/pwr_dvfs_ctrl_chk.sv
module pwr_dvfs_ctrl_chk #(
    parameter int LW = 2,
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          vgood,
    input logic          cpu_idle,
    input logic          wake_req,
    input logic [LW-1:0] freq_lvl,
    input logic [LW-1:0] volt_lvl,
    input logic          cpu_clk_en,
    input logic [NP-1:0] periph_clk_en,
    input logic          settle_err
);
    // R5
    no_joint_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(freq_lvl) && !$stable(volt_lvl)));

    // R5
    volt_covers_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        volt_lvl >= freq_lvl);

    // R3
    raise_after_vgood_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_lvl > $past(freq_lvl)) |-> $past(vgood));

    // R9
    cpu_gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cpu_clk_en == (!$past(cpu_idle) || $past(wake_req))));

    // R10
    periph_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(periph_clk_en) |-> ($past(req_valid) && !$past(busy)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settle_err |=> (settle_err && busy));

    // R8
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settle_err |=> ($stable(freq_lvl) && $stable(volt_lvl)));
endmodule

bind pwr_dvfs_ctrl pwr_dvfs_ctrl_chk #(.LW(LW), .NP(NUM_PERIPH)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .busy(busy),
    .vgood(vgood),
    .cpu_idle(cpu_idle),
    .wake_req(wake_req),
    .freq_lvl(freq_lvl),
    .volt_lvl(volt_lvl),
    .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en),
    .settle_err(settle_err)
);

// File: tb/pwr_dvfs_ctrl_tb_top.sv
module pwr_dvfs_ctrl_tb_top;
    localparam int NL   = 4;
    localparam int CW   = 16;
    localparam int DW   = 8;
    localparam int NP   = 4;
    localparam int TMO  = 8;
    localparam int LW   = 2;
    localparam int NVEC = 8;

    localparam int VEC_CYC [NVEC] = '{30, 50, 160, 161, 81, 80, 5, 0};
    localparam int VEC_DL  [NVEC] = '{10, 10, 10, 10, 10, 10, 0, 0};
    localparam int VEC_MSK [NVEC] = '{1, 3, 8, 4, 10, 5, 15, 0};
    localparam int VEC_EXP [NVEC] = '{0, 1, 3, 3, 2, 1, 3, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_cycles = '0;
    logic [DW-1:0] req_deadline = '0;
    logic [NP-1:0] req_periph = '0;
    logic          cpu_idle = 1'b0;
    logic          wake_req = 1'b0;
    logic          vgood = 1'b1;
    logic [LW-1:0] freq_lvl, volt_lvl;
    logic          cpu_clk_en, busy, settle_err;
    logic [NP-1:0] periph_clk_en;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwr_dvfs_ctrl #(
        .NUM_LVL(NL), .CYC_W(CW), .DL_W(DW), .NUM_PERIPH(NP),
        .FMIN(4), .DELTA_F(4), .ALPHA_STEP(1), .SETTLE_TMO(TMO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_cycles(req_cycles), .req_deadline(req_deadline),
        .req_periph(req_periph), .cpu_idle(cpu_idle), .wake_req(wake_req),
        .vgood(vgood), .freq_lvl(freq_lvl), .volt_lvl(volt_lvl),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
        .busy(busy), .settle_err(settle_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        vgood = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 16; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic issue(input int cyc, input int dl, input int msk);
        @(negedge clk);
        req_cycles   = CW'(cyc);
        req_deadline = DW'(dl);
        req_periph   = NP'(msk);
        req_valid    = 1'b1;
        vgood        = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic full_req(input int cyc, input int dl, input int msk);
        issue(cyc, dl, msk);
        @(negedge clk);
        vgood = 1'b1;
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 freq", int'(freq_lvl), 3);
        check("R1 volt", int'(volt_lvl), 3);
        check("R1 cpu_en", int'(cpu_clk_en), 1);
        check("R1 periph", int'(periph_clk_en), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(settle_err), 0);

        // R2 / R10 vector walk
        for (int v = 0; v < NVEC; v++) begin
            full_req(VEC_CYC[v], VEC_DL[v], VEC_MSK[v]);
            check("R2 freq", int'(freq_lvl), VEC_EXP[v]);
            check("R2 volt", int'(volt_lvl), VEC_EXP[v]);
            check("R10 periph", int'(periph_clk_en), VEC_MSK[v]);
            check("R11 busy done", int'(busy), 0);
        end

        // R3 raise ordering from level 0 to 3
        issue(200, 1, 2);
        check("R3 volt first", int'(volt_lvl), 3);
        check("R3 freq held", int'(freq_lvl), 0);
        check("R11 busy", int'(busy), 1);
        repeat (3) @(negedge clk);
        check("R3 freq waits vgood", int'(freq_lvl), 0);
        vgood = 1'b1;
        @(negedge clk);
        check("R3 freq after vgood", int'(freq_lvl), 3);
        check("R11 busy clears", int'(busy), 0);

        // R4 lower ordering from 3 to 0
        issue(1, 1, 2);
        check("R4 freq first", int'(freq_lvl), 0);
        check("R4 volt held", int'(volt_lvl), 3);
        @(negedge clk);
        check("R4 volt next", int'(volt_lvl), 0);
        check("R4 waiting", int'(busy), 1);
        vgood = 1'b1;
        @(negedge clk);
        check("R4 done", int'(busy), 0);

        // R6 same level: no transition, mask loads
        issue(1, 1, 9);
        check("R6 no busy", int'(busy), 0);
        check("R6 freq", int'(freq_lvl), 0);
        check("R6 mask", int'(periph_clk_en), 9);
        vgood = 1'b1;

        // R7 request while busy is ignored
        issue(200, 1, 6);
        req_cycles   = CW'(1);
        req_deadline = DW'(1);
        req_periph   = NP'(1);
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 mask kept", int'(periph_clk_en), 6);
        vgood = 1'b1;
        wait_idle();
        check("R7 level kept", int'(freq_lvl), 3);
        check("R7 mask final", int'(periph_clk_en), 6);

        // R9 processor clock gating and wake
        cpu_idle = 1'b1;
        @(negedge clk);
        check("R9 gated", int'(cpu_clk_en), 0);
        wake_req = 1'b1;
        @(negedge clk);
        check("R9 wake", int'(cpu_clk_en), 1);
        wake_req = 1'b0;
        @(negedge clk);
        check("R9 regate", int'(cpu_clk_en), 0);
        cpu_idle = 1'b0;
        @(negedge clk);
        check("R9 resume", int'(cpu_clk_en), 1);

        // R8 lower timeout: voltage restored to the old level
        issue(1, 1, 3);
        repeat (TMO + 3) @(negedge clk);
        check("R8 err lower", int'(settle_err), 1);
        check("R8 volt restored", int'(volt_lvl), 3);
        check("R8 freq low", int'(freq_lvl), 0);

        // R8 fault ignores requests
        vgood = 1'b1;
        issue(200, 1, 12);
        vgood = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 fault freq", int'(freq_lvl), 0);
        check("R8 fault mask", int'(periph_clk_en), 3);
        check("R8 fault busy", int'(busy), 1);

        // R8 raise timeout: frequency stays at the old level
        do_reset();
        full_req(1, 1, 0);
        check("R8 setup", int'(freq_lvl), 0);
        issue(200, 1, 0);
        repeat (TMO + 3) @(negedge clk);
        check("R8 err raise", int'(settle_err), 1);
        check("R8 raise freq", int'(freq_lvl), 0);
        check("R8 raise volt", int'(volt_lvl), 3);

        do_reset();
        @(negedge clk);
        check("R1 err cleared", int'(settle_err), 0);

        summary();
        $finish;
    end
endmodule